// File: doc/BRIEF.md
# Per-Channel Offset Correction and Alignment Stage

This stage sits between a converter's raw 12-bit result and the 16-bit words that software reads. Each result arrives with its channel number and a tag that marks it as a regular or an injected conversion. Four offset slots are available. Each slot holds a channel number, a 12-bit offset, an enable, a direction bit (subtract or add) and a saturation enable.

For every valid input, the stage looks for enabled slots whose channel matches the result's channel. The lowest-numbered matching slot wins. The winning slot's offset is applied in the chosen direction. The corrected value is clamped if that slot asks for it, and the value is then placed right- or left-aligned in a 16-bit word. The result appears exactly one clock after the input, together with its channel and group tag. Regular and injected results go through the same path.

Top module: `chan_ofs_align`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` is 0 and `out_data` is 0x0000.
- R2: Every cycle in which `in_valid` is 1 produces exactly one cycle with `out_valid` = 1, one clock later. `out_chan` and `out_inj` carry that input's channel and group tag.
- R3: For a matching slot whose direction bit is 0, the slot offset is subtracted from the raw value.
- R4: For a matching slot whose direction bit is 1, the slot offset is added to the raw value.
- R5: For a matching slot whose saturation bit is 1, a negative corrected value becomes 0x000 and a value above 0xFFF becomes 0xFFF. A right-aligned word then has bits 15:12 equal to 0.
- R6: Without saturation, the corrected value is a signed 14-bit number. When right-aligned, it is sign-extended to 16 bits (raw 0x010 minus 0x020 gives 0xFFF0; raw 0xFF0 plus 0x020 gives 0x1010).
- R7: When several enabled slots name the input's channel, only the slot with the lowest index is applied.
- R8: A slot whose enable is 0 has no effect. A result that matches no enabled slot leaves the stage as its raw value, changed only by alignment.
- R9: When `align_left` is 1, bits 11:0 of the (possibly clamped) corrected value occupy bits 15:4 of the word, and bits 3:0 are 0.
- R10: Injected results (`in_inj` = 1) receive the same offset, saturation and alignment as regular ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | NSLOT | Per-slot enable |
| slot_chan | input | NSLOT*CH_W | Per-slot channel number; slot i occupies bits [i*CH_W +: CH_W] |
| slot_ofs | input | NSLOT*12 | Per-slot offset; slot i occupies bits [i*12 +: 12] |
| slot_pos | input | NSLOT | Per-slot direction: 0 subtract, 1 add |
| slot_sat | input | NSLOT | Per-slot clamp to 0x000..0xFFF |
| align_left | input | 1 | 0 right alignment, 1 left alignment |
| in_valid | input | 1 | Input result valid |
| in_chan | input | CH_W | Channel of the input result |
| in_inj | input | 1 | 1 for an injected result, 0 for a regular one |
| in_data | input | 12 | Raw conversion value |
| out_valid | output | 1 | Output word valid |
| out_chan | output | CH_W | Channel of the output word |
| out_inj | output | 1 | Group tag of the output word |
| out_data | output | 16 | Corrected, aligned word |

## Verification
Two things can happen in the same cycle. A new input can be captured on the same edge that presents the previous result. The clamp and the left shift can also act on one value. To provoke the first case, the bench sends bursts with `in_valid` held high across several cycles on different channels. Each emitted word is checked for order and for the exact cycle it appears in, so a lost, repeated or delayed word is reported. The second case is provoked by saturating inputs while left alignment is selected. The expected word is the clamped value shifted up by four.

// File: rtl/cofs_pkg.sv
package cofs_pkg;
  localparam int RAW_W = 12;
  localparam int OUT_W = 16;
  localparam int EXT_W = RAW_W + 2;
  localparam int PAD_W = OUT_W - RAW_W;

  typedef logic [RAW_W-1:0]        raw_t;
  typedef logic signed [EXT_W-1:0] ext_t;
  typedef logic [OUT_W-1:0]        word_t;

  // Signed corrected value: raw +/- offset, or raw unchanged when no slot hits.
  function automatic ext_t offset_apply(raw_t raw, raw_t ofs, logic hit, logic pos);
    ext_t r;
    ext_t o;
    r = $signed({2'b00, raw});
    o = $signed({2'b00, ofs});
    if (!hit)     return r;
    else if (pos) return r + o;
    else          return r - o;
  endfunction

  // Clamp a signed corrected value into the unsigned raw range.
  function automatic raw_t clamp_raw(ext_t v);
    if (v[EXT_W-1])               return '0;
    else if (|v[EXT_W-2:RAW_W])   return '1;
    else                          return v[RAW_W-1:0];
  endfunction

  // Place the corrected value into the output word.
  function automatic word_t align_word(ext_t v, logic left);
    if (left) return {v[RAW_W-1:0], {PAD_W{1'b0}}};
    else      return {{(OUT_W-EXT_W){v[EXT_W-1]}}, v};
  endfunction
endpackage

// File: rtl/cofs_slot_match.sv
module cofs_slot_match #(
  parameter int NSLOT = 4,
  parameter int CH_W  = 5,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic [CH_W-1:0]       chan,
  input  logic [NSLOT-1:0]      en,
  input  logic [NSLOT*CH_W-1:0] chans,
  output logic [NSLOT-1:0]      hit_vec,
  output logic [NSLOT-1:0]      grant,
  output logic                  any_hit,
  output logic [IDX_W-1:0]      sel_idx
);
  genvar gi;
  generate
    for (gi = 0; gi < NSLOT; gi++) begin : g_cmp
      assign hit_vec[gi] = en[gi] && (chans[gi*CH_W +: CH_W] == chan);
    end
  endgenerate

  // Lowest index wins: scan from the top so lower slots overwrite.
  always_comb begin
    grant   = '0;
    sel_idx = '0;
    for (int i = NSLOT-1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        grant      = '0;
        grant[i]   = 1'b1;
        sel_idx    = IDX_W'(i);
      end
    end
  end

  assign any_hit = |hit_vec;
endmodule

// File: rtl/cofs_correct.sv
module cofs_correct
  import cofs_pkg::*;
(
  input  raw_t raw,
  input  raw_t ofs,
  input  logic hit,
  input  logic pos,
  input  logic sat,
  output ext_t corr,
  output logic sat_on
);
  ext_t sum;
  raw_t clamped;

  assign sum     = offset_apply(raw, ofs, hit, pos);
  assign clamped = clamp_raw(sum);
  assign sat_on  = hit && sat;
  assign corr    = sat_on ? $signed({2'b00, clamped}) : sum;
endmodule

// File: rtl/cofs_align.sv
module cofs_align
  import cofs_pkg::*;
(
  input  ext_t  corr,
  input  logic  left,
  output word_t word
);
  assign word = align_word(corr, left);
endmodule

// File: rtl/chan_ofs_align.sv
module chan_ofs_align
  import cofs_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int CH_W  = 5,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOT-1:0]       slot_en,
  input  logic [NSLOT*CH_W-1:0]  slot_chan,
  input  logic [NSLOT*RAW_W-1:0] slot_ofs,
  input  logic [NSLOT-1:0]       slot_pos,
  input  logic [NSLOT-1:0]       slot_sat,
  input  logic                   align_left,
  input  logic                   in_valid,
  input  logic [CH_W-1:0]        in_chan,
  input  logic                   in_inj,
  input  logic [RAW_W-1:0]       in_data,
  output logic                   out_valid,
  output logic [CH_W-1:0]        out_chan,
  output logic                   out_inj,
  output logic [OUT_W-1:0]       out_data
);
  logic [NSLOT-1:0] hit_vec;
  logic [NSLOT-1:0] grant;
  logic             any_hit;
  logic [IDX_W-1:0] sel_idx;
  raw_t             sel_ofs;
  logic             sel_pos;
  logic             sel_sat;
  ext_t             corr;
  logic             sat_on;
  word_t            word_next;

  cofs_slot_match #(.NSLOT(NSLOT), .CH_W(CH_W)) u_match (
    .chan    (in_chan),
    .en      (slot_en),
    .chans   (slot_chan),
    .hit_vec (hit_vec),
    .grant   (grant),
    .any_hit (any_hit),
    .sel_idx (sel_idx)
  );

  assign sel_ofs = slot_ofs[sel_idx*RAW_W +: RAW_W];
  assign sel_pos = slot_pos[sel_idx];
  assign sel_sat = slot_sat[sel_idx];

  cofs_correct u_corr (
    .raw    (in_data),
    .ofs    (sel_ofs),
    .hit    (any_hit),
    .pos    (sel_pos),
    .sat    (sel_sat),
    .corr   (corr),
    .sat_on (sat_on)
  );

  cofs_align u_align (
    .corr (corr),
    .left (align_left),
    .word (word_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_inj   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_chan <= in_chan;
        out_inj  <= in_inj;
        out_data <= word_next;
      end
    end
  end
endmodule

// File: rtl/cofs_chk.sv
module cofs_chk
  import cofs_pkg::*;
#(
  parameter int NSLOT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [RAW_W-1:0] in_data,
  input logic             align_left,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic [NSLOT-1:0] hit_vec,
  input logic [NSLOT-1:0] grant,
  input logic             any_hit,
  input logic             sat_on
);
  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  // R7
  low_slot_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vec[0] |-> (grant == NSLOT'(1)));

  // R7
  grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~hit_vec) == '0) && (any_hit == (grant != '0)));

  // R5
  sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && out_valid && $past(in_valid && sat_on && !align_left))
      |-> (out_data[OUT_W-1:RAW_W] == '0));

  // R9
  left_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && out_valid && $past(in_valid && align_left))
      |-> (out_data[PAD_W-1:0] == '0));

  // R8
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && out_valid && $past(in_valid && !any_hit && !align_left))
      |-> (out_data == {{PAD_W{1'b0}}, $past(in_data)}));
endmodule

bind chan_ofs_align cofs_chk #(.NSLOT(NSLOT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .align_left (align_left),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .hit_vec    (hit_vec),
  .grant      (grant),
  .any_hit    (any_hit),
  .sat_on     (sat_on)
);

// File: tb/chan_ofs_align_tb.sv
module chan_ofs_align_tb;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]       s_en = '0, s_pos = '0, s_sat = '0;
  logic [3:0][4:0]  s_ch = '0;
  logic [3:0][11:0] s_ofs = '0;
  logic             align_l = 1'b0;
  logic             in_valid = 1'b0;
  logic [4:0]       in_chan = '0;
  logic             in_inj = 1'b0;
  logic [11:0]      in_data = '0;
  logic             out_valid;
  logic [4:0]       out_chan;
  logic             out_inj;
  logic [15:0]      out_data;

  int checks = 0;
  int errors = 0;
  int cycle = 0;

  int    exp_q[$];
  int    cyc_q[$];
  int    ch_q[$];
  bit    inj_q[$];
  string tag_q[$];

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  chan_ofs_align u_dut (
    .clk(clk), .rst_n(rst_n),
    .slot_en(s_en), .slot_chan(s_ch), .slot_ofs(s_ofs),
    .slot_pos(s_pos), .slot_sat(s_sat), .align_left(align_l),
    .in_valid(in_valid), .in_chan(in_chan), .in_inj(in_inj), .in_data(in_data),
    .out_valid(out_valid), .out_chan(out_chan), .out_inj(out_inj), .out_data(out_data)
  );

  // Independent model of the requirements, in plain integers.
  function automatic int model(int ch, int raw);
    int v;
    v = raw;
    for (int i = 0; i < 4; i++) begin
      if (s_en[i] && int'(s_ch[i]) == ch) begin
        if (s_pos[i]) v = raw + int'(s_ofs[i]);
        else          v = raw - int'(s_ofs[i]);
        if (s_sat[i]) begin
          if (v < 0)    v = 0;
          if (v > 4095) v = 4095;
        end
        break;
      end
    end
    if (align_l) return (v & 32'hFFF) << 4;
    return v & 32'hFFFF;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(int ch, int raw, bit inj, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_chan  = 5'(ch);
    in_data  = 12'(raw);
    in_inj   = inj;
    exp_q.push_back(model(ch, raw));
    cyc_q.push_back(cycle + 1);
    ch_q.push_back(ch);
    inj_q.push_back(inj);
    tag_q.push_back(tag);
  endtask

  // Ends any input pulse before configuration changes.
  task automatic quiesce();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected word", int'(out_data), 0);
      end else begin
        int e, c, ch;
        bit ij;
        string t;
        e = exp_q.pop_front(); c = cyc_q.pop_front();
        ch = ch_q.pop_front(); ij = inj_q.pop_front(); t = tag_q.pop_front();
        check(int'(out_data) == e, t, int'(out_data), e);
        check(cycle == c && int'(out_chan) == ch && out_inj == ij,
              "R2 timing/chan/tag", cycle, c);
      end
    end
  end

  initial begin
    #(CLK_NS * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_data == 16'h0, "R1 reset", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == 16'h0, "R1 after reset", int'(out_data), 0);

    // R8: nothing enabled, slot data present but disabled
    s_ch[0] = 5'd3; s_ofs[0] = 12'h020;
    send(3, 'h123, 0, "R8 disabled slot");
    quiesce();
    // R3 subtract
    s_en[0] = 1'b1;
    send(3, 'h123, 0, "R3 subtract");
    send(4, 'h123, 0, "R8 no match");
    quiesce();
    // R4 add
    s_pos[0] = 1'b1;
    send(3, 'h123, 0, "R4 add");
    quiesce();
    // R6 signed without saturation
    s_pos[0] = 1'b0;
    send(3, 'h010, 0, "R6 negative sign-extend");
    quiesce();
    s_pos[0] = 1'b1;
    send(3, 'hFF0, 0, "R6 above range");
    quiesce();
    // R5 saturation
    s_sat[0] = 1'b1;
    send(3, 'hFF0, 0, "R5 clamp high");
    quiesce();
    s_pos[0] = 1'b0;
    send(3, 'h010, 0, "R5 clamp low");
    // R7 priority: slots 1 and 2 both on channel 7
    quiesce();
    s_en[1] = 1'b1; s_ch[1] = 5'd7; s_ofs[1] = 12'h001;
    s_en[2] = 1'b1; s_ch[2] = 5'd7; s_ofs[2] = 12'h100;
    send(7, 'h500, 0, "R7 lowest index");
    quiesce();
    s_en[1] = 1'b0;
    send(7, 'h500, 0, "R8 disabled skipped");
    // R10 injected
    send(7, 'h500, 1, "R10 injected");
    send(3, 'h123, 1, "R10 injected subtract");
    quiesce();
    // R9 left alignment, alone and with saturation in the same value
    align_l = 1'b1;
    send(9, 'h123, 0, "R9 left plain");
    send(3, 'h010, 0, "R9 left with clamp");
    quiesce();
    s_sat[0] = 1'b0;
    send(3, 'h010, 0, "R9 left negative");
    quiesce();
    align_l = 1'b0;
    // R2 back-to-back burst over several channels
    for (int k = 0; k < 8; k++) send(k % 2 == 0 ? 3 : 7, 16 * k + 5, k[0], "R2 burst");
    quiesce();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all words emitted", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule